// File: doc/BRIEF.md
# Two-Key Register Write Unlock

This block guards a peripheral's configuration registers against stray writes. After reset the block is locked. While it is locked, every bus write aimed at a protected register is dropped, and reads carry on as normal. Software opens the gate by writing two 32-bit key words in a fixed order, one to each of two kick registers. A readable status bit then reports that the gate is open. Software can read this bit first and skip the key sequence when the gate is already open.

The bus side is a single-cycle write strobe with a byte address and a data word. The block raises `prot_wr_ok` in the same cycle as a bus write that the protected register file may accept. The protected registers take the address and the data straight from the bus. The block holds none of their contents.

The sequencer is a three-state machine. LOCKED is the reset state and waits for the first key. ARMED means the first key was accepted and the second is awaited. OPEN means writes pass. The transitions are as follows:
- ARM: a correct first key, from LOCKED.
- OPEN_UP: a correct second key, from ARMED.
- REARM: a repeated correct first key, which keeps ARMED.
- ABORT: any wrong key, a second key written out of order, or any other write, all from ARMED back to LOCKED.
- RELOCK: a wrong key written to either kick register, from OPEN to LOCKED.
- HOLD: correct keys or protected writes, which keep OPEN.

Top module: `unlk_gate`

## Requirements
- R1: After reset the block is LOCKED. The status bit (bit 23 of the status word at byte offset 0x50) reads 0, and `prot_wr_ok` is 0.
- R2: A write of 0x83E70B13 to offset 0x70, followed as the next bus write by a write of 0x95A4F1E0 to offset 0x74, opens the gate. The status bit reads 1 from the clock cycle after the second write.
- R3: A correct second-key write that does not come straight after a correct first-key write leaves the block locked. This includes the keys written in reverse order.
- R4: A wrong value written to either kick register sends the sequence back to LOCKED. If the gate was OPEN, it closes. The first key is then required again.
- R5: Any bus write to a non-kick address between the first and the second key cancels the sequence. The block returns to LOCKED.
- R6: While the block is not OPEN, `prot_wr_ok` stays 0 for every write. While it is OPEN, `prot_wr_ok` is 1 in the same cycle as any write to a non-kick address.
- R7: A write to either kick register never asserts `prot_wr_ok`.
- R8: A read at offset 0x50 returns the status bit in bit 23 and zeros in all other bits. A read at any other offset returns 0. Reads are served in every state.
- R9: A repeated correct first key while ARMED keeps ARMED. Correct key writes while OPEN keep the gate OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | ADDR_W | Write byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_raddr | input | ADDR_W | Read byte address for the status word |
| bus_rdata | output | DATA_W | Status read data, combinational |
| prot_wr_ok | output | 1 | Write enable for the protected register file |
| unlocked | output | 1 | Gate is OPEN |

## Verification
The assertions assume one write per cycle, carried by a one-cycle `bus_wr` with a stable address and data. They also assume that the reset is held for at least one clock edge before any write. The bench changes inputs only at the falling edge and presents at most one write each clock. It mixes kick addresses, the status offset and random aligned addresses. It biases the data toward the two keys so that every transition of the machine is taken many times. It always applies reset before the first stimulus and before mid-run resets.

// File: rtl/unlk_pkg.sv
package unlk_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_OPEN   = 2'd2
    } unlk_state_e;

    // One decoded bus write, as seen by the sequencer
    typedef struct packed {
        logic wr;      // a write is present this cycle
        logic hit0;    // write targets the first kick register
        logic good0;   // data equals the first key
        logic hit1;    // write targets the second kick register
        logic good1;   // data equals the second key
    } kick_evt_t;

    localparam int NUM_KICKS = 2;

endpackage

// File: rtl/unlk_kick_decode.sv
module unlk_kick_decode
    import unlk_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] KICK0_ADDR = 8'h70,
    parameter logic [ADDR_W-1:0] KICK1_ADDR = 8'h74,
    parameter logic [DATA_W-1:0] KEY0       = 32'h83E70B13,
    parameter logic [DATA_W-1:0] KEY1       = 32'h95A4F1E0
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output kick_evt_t         evt,
    output logic              is_kick
);

    localparam logic [NUM_KICKS-1:0][ADDR_W-1:0] SLOT_ADDR = {KICK1_ADDR, KICK0_ADDR};
    localparam logic [NUM_KICKS-1:0][DATA_W-1:0] SLOT_KEY  = {KEY1, KEY0};

    logic [NUM_KICKS-1:0] hit;
    logic [NUM_KICKS-1:0] good;

    for (genvar g = 0; g < NUM_KICKS; g++) begin : g_slot
        always_comb begin
            hit[g]  = wr && (addr == SLOT_ADDR[g]);
            good[g] = (data == SLOT_KEY[g]);
        end
    end

    always_comb begin
        evt.wr    = wr;
        evt.hit0  = hit[0];
        evt.good0 = good[0];
        evt.hit1  = hit[1];
        evt.good1 = good[1];
        is_kick   = |hit;
    end

endmodule

// File: rtl/unlk_seq_fsm.sv
module unlk_seq_fsm
    import unlk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  kick_evt_t   evt,
    output unlk_state_e state,
    output logic        open_q
);

    unlk_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state;
        if (evt.wr) begin
            unique case (state)
                ST_LOCKED: begin
                    if (evt.hit0 && evt.good0) state_d = ST_ARMED;    // ARM
                end
                ST_ARMED: begin
                    if (evt.hit0 && evt.good0)      state_d = ST_ARMED;  // REARM
                    else if (evt.hit1 && evt.good1) state_d = ST_OPEN;   // OPEN_UP
                    else                            state_d = ST_LOCKED; // ABORT
                end
                ST_OPEN: begin
                    if ((evt.hit0 && !evt.good0) || (evt.hit1 && !evt.good1))
                        state_d = ST_LOCKED;                           // RELOCK
                end
                default: state_d = ST_LOCKED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_OPEN: open_q = 1'b1;
            default: open_q = 1'b0;
        endcase
    end

    // R2: the gate only opens straight after a correct second key seen while armed
    assert_open_needs_key1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> $past(state == ST_ARMED && evt.hit1 && evt.good1));

    // R4: a wrong key on either kick register always leaves the gate closed
    assert_wrong_key_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt.hit0 && !evt.good0) || (evt.hit1 && !evt.good1)) |=> (state == ST_LOCKED));

    // R5: a non-kick write while armed cancels the sequence
    assert_intervening_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && evt.wr && !evt.hit0 && !evt.hit1) |=> (state == ST_LOCKED));

    // R3: arming only follows a correct first key
    assert_arm_needs_key0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && $past(state) != ST_ARMED) |-> $past(evt.hit0 && evt.good0));

endmodule

// File: rtl/unlk_gate.sv
module unlk_gate
    import unlk_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] KICK0_ADDR  = 8'h70,
    parameter logic [ADDR_W-1:0] KICK1_ADDR  = 8'h74,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h50,
    parameter int                STATUS_BIT  = 23,
    parameter logic [DATA_W-1:0] KEY0        = 32'h83E70B13,
    parameter logic [DATA_W-1:0] KEY1        = 32'h95A4F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prot_wr_ok,
    output logic              unlocked
);

    kick_evt_t   evt;
    logic        is_kick;
    unlk_state_e state;
    logic        open_q;

    unlk_kick_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KICK0_ADDR(KICK0_ADDR), .KICK1_ADDR(KICK1_ADDR),
        .KEY0(KEY0), .KEY1(KEY1)
    ) u_dec (
        .wr(bus_wr), .addr(bus_waddr), .data(bus_wdata),
        .evt(evt), .is_kick(is_kick)
    );

    unlk_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .state(state), .open_q(open_q)
    );

    always_comb begin
        prot_wr_ok = bus_wr && open_q && !is_kick;
        unlocked   = open_q;
        bus_rdata  = '0;
        if (bus_raddr == STATUS_ADDR) bus_rdata[STATUS_BIT] = open_q;
    end

    // R7: kick writes are never forwarded to the protected registers
    assert_kick_not_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_waddr == KICK0_ADDR || bus_waddr == KICK1_ADDR)) |-> !prot_wr_ok);

    // R6: forwarded writes only happen in the open state of the sequencer
    assert_locked_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr_ok |-> (state == ST_OPEN));

    // R8: the status word carries at most the one status bit
    assert_status_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_rdata) <= 1);

endmodule

// File: tb/sim_unlk_gate.sv
module sim_unlk_gate;

    localparam logic [7:0]  A_K0  = 8'h70;
    localparam logic [7:0]  A_K1  = 8'h74;
    localparam logic [7:0]  A_ST  = 8'h50;
    localparam logic [31:0] KEY0  = 32'h83E70B13;
    localparam logic [31:0] KEY1  = 32'h95A4F1E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  bus_raddr = A_ST;
    logic [31:0] bus_rdata;
    logic        prot_wr_ok;
    logic        unlocked;

    int n_checks = 0;
    int n_fail   = 0;
    int mst      = 0;   // bench model: 0 locked, 1 armed, 2 open
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    unlk_gate u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .prot_wr_ok(prot_wr_ok), .unlocked(unlocked)
    );

    function automatic int model_next(int s, logic [7:0] a, logic [31:0] d);
        if (a == A_K0) begin
            if (d != KEY0) return 0;
            return (s == 2) ? 2 : 1;
        end
        if (a == A_K1) begin
            if (d != KEY1) return 0;
            return (s == 0) ? 0 : 2;
        end
        return (s == 1) ? 0 : s;
    endfunction

    function automatic logic [31:0] model_status(int s, logic [7:0] ra);
        logic [31:0] v = '0;
        if (ra == A_ST) v[23] = (s == 2);
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_status(string req);
        chk(bus_rdata == model_status(mst, bus_raddr), req, bus_rdata,
            model_status(mst, bus_raddr));
        chk(unlocked == (mst == 2), req, {31'd0, unlocked}, {31'd0, mst == 2});
    endtask

    // One write: check the same-cycle enable, then the status after the edge
    task automatic do_wr(logic [7:0] a, logic [31:0] d, string req);
        bit kick;
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        #1;
        kick = (a == A_K0) || (a == A_K1);
        chk(prot_wr_ok == ((mst == 2) && !kick),
            kick ? {req, " R7 kick enable"} : {req, " R6 write enable"},
            {31'd0, prot_wr_ok}, {31'd0, (mst == 2) && !kick});
        @(posedge clk);
        mst = model_next(mst, a, d);
        #1;
        bus_wr = 1'b0;
        check_status(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        @(posedge clk);
        mst = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_status("R1 reset state");
        chk(prot_wr_ok == 1'b0, "R1 reset enable", {31'd0, prot_wr_ok}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED1234));
        repeat (2) @(posedge clk);
        do_reset();

        // R1: a protected write right after reset is dropped
        do_wr(8'h10, 32'hDEADBEEF, "R1 locked write");
        // R2: correct sequence opens the gate
        do_wr(A_K0, KEY0, "R2 key0");
        chk(unlocked == 1'b0, "R2 armed not open", {31'd0, unlocked}, 32'd0);
        do_wr(A_K1, KEY1, "R2 key1");
        chk(bus_rdata == 32'h0080_0000, "R2 status bit 23", bus_rdata, 32'h0080_0000);
        do_wr(8'h10, 32'h1, "R6 open write");
        // R9: correct keys while open keep it open
        do_wr(A_K0, KEY0, "R9 key0 while open");
        do_wr(A_K1, KEY1, "R9 key1 while open");
        // R4: wrong key relocks
        do_wr(A_K1, 32'h0, "R4 wrong key1 relock");
        chk(unlocked == 1'b0, "R4 relocked", {31'd0, unlocked}, 32'd0);
        // R3: reverse order stays locked
        do_wr(A_K1, KEY1, "R3 reverse key1");
        do_wr(A_K0, KEY0, "R3 reverse key0");
        chk(unlocked == 1'b0, "R3 reverse order", {31'd0, unlocked}, 32'd0);
        // R9: repeated key0 keeps armed
        do_wr(A_K0, KEY0, "R9 key0 again");
        do_wr(A_K1, KEY1, "R9 open after repeat");
        chk(unlocked == 1'b1, "R9 repeat then key1", {31'd0, unlocked}, 32'd1);
        do_reset();
        // R5: intervening write cancels
        do_wr(A_K0, KEY0, "R5 key0");
        do_wr(A_ST, 32'h0, "R5 intervening");
        do_wr(A_K1, KEY1, "R5 key1 after gap");
        chk(unlocked == 1'b0, "R5 cancelled", {31'd0, unlocked}, 32'd0);
        // R4: wrong key0 after arming
        do_wr(A_K0, KEY0, "R4 arm");
        do_wr(A_K0, KEY0 ^ 32'h1, "R4 wrong key0");
        do_wr(A_K1, KEY1, "R4 key1 after wrong");
        chk(unlocked == 1'b0, "R4 needs key0 again", {31'd0, unlocked}, 32'd0);
        // R8: read at another offset returns zero
        do_wr(A_K0, KEY0, "R8 arm");
        do_wr(A_K1, KEY1, "R8 open");
        @(negedge clk); bus_raddr = 8'h54; #1;
        chk(bus_rdata == 32'h0, "R8 other offset", bus_rdata, 32'h0);
        bus_raddr = A_ST; #1;
        chk(bus_rdata == 32'h0080_0000, "R8 status offset", bus_rdata, 32'h0080_0000);
        // R1: reset while open locks again
        do_reset();

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int sel = $urandom_range(0, 9);
            if (sel < 4)      a = A_K0;
            else if (sel < 8) a = A_K1;
            else if (sel < 9) a = A_ST;
            else              a = 8'($urandom_range(0, 63) * 4);
            if ($urandom_range(0, 9) < 7) d = (a == A_K1) ? KEY1 : KEY0;
            else                          d = $urandom;
            if ($urandom_range(0, 15) == 0) begin
                @(negedge clk);
                bus_raddr = 8'($urandom_range(0, 63) * 4);
                #1;
                chk(bus_rdata == model_status(mst, bus_raddr), "R8 random read",
                    bus_rdata, model_status(mst, bus_raddr));
                bus_raddr = A_ST;
            end
            if ($urandom_range(0, 199) == 0) do_reset();
            else do_wr(a, d, "R6 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule